// File: doc/BRIEF.md
# Exhaustive Self-Test Checker for a Small Logic Function

This block holds a fixed four-input, four-output combinational function and a built-in checker for it. In normal operation the function is driven from the external inputs, and both indicator lamps stay dark. When the test switch is raised, the external inputs are cut off. A free-running 4-bit stimulus counter then feeds the function with every input code in turn.

A register table of expected results steps forward one word per clock, locked to that counter. Each expected word covers the four primary outputs and three internal gate nodes. The comparison against the live values lights either an OK lamp or a warning lamp one clock later.

A debug input can invert one chosen internal node. A testbench uses it to confirm that the checker catches faults, including faults that never reach the primary outputs. The expected table can be built as a rotating register ring or as a fixed table read through a pointer. Both forms are selected by a parameter and behave the same at the ports.

Top module: `exh_logic_selftest`

## Requirements
- R1: While `test_en` is 1, the function input comes only from the stimulus counter, and `ext_in` has no effect on `out_wxyz` or on the lamps.
- R2: In test mode the counter starts at 0 after reset, rises by one per clock, and wraps from 15 to 0. Input code bit 3 is A, bit 2 is B, bit 1 is C and bit 0 is D.
- R3: `out_wxyz` is {W,X,Y,Z} with W in bit 3, where W = (A&B)|(C&D), X = A^B, Y = ~(B|C) and Z = (A&~D)|(B&C).
- R4: Each compared word is {W,X,Y,Z,A&B,C&D,B&C}, so a wrong internal node raises the warning even when every primary output is correct.
- R5: On the clock after a cycle in test mode whose live word equals the expected word for the current code, `ok_lamp` is 1 and `warn_lamp` is 0.
- R6: On the clock after a cycle in test mode with any compared bit differing, `warn_lamp` is 1 and `ok_lamp` is 0. The two lamps are never both 1.
- R7: On the clock after a cycle with `test_en` at 0, both lamps are 0. `out_wxyz` then follows `ext_in` without a clock. The counter and the table hold their position, so test mode resumes at the next code and stays aligned.
- R8: Reset (`rst_n` low, asynchronous) returns the counter and the expected table to code 0 and clears both lamps.
- R9: With `dbg_flip_en` at 1, `dbg_flip_sel` selects the node to invert: 2 inverts A&B, 1 inverts C&D, 0 inverts B&C, and 3 inverts nothing. The inverted node also feeds W or Z.
- R10: Both table forms (`SEQ_STYLE` 0 ring, 1 pointer) produce identical port behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Test switch: 1 runs the exhaustive self-test |
| ext_in | input | 4 | External inputs {A,B,C,D}, A in bit 3 |
| dbg_flip_en | input | 1 | Enables inversion of one internal node |
| dbg_flip_sel | input | 2 | Selects the node to invert |
| out_wxyz | output | 4 | Function outputs {W,X,Y,Z}, W in bit 3 |
| ok_lamp | output | 1 | All compared bits matched on the last test cycle |
| warn_lamp | output | 1 | A compared bit differed on the last test cycle |

## Verification
The bench builds two copies side by side from the same stimulus. One uses the default ring table (`SEQ_STYLE` = 0) and one uses the pointer table (`SEQ_STYLE` = 1), so every scenario checks both sequencer forms against the same expected values. The width parameters stay at their defaults of 4 inputs and 3 nodes, which keeps a full 16-code sweep and its wrap within a few dozen clocks. That short sweep lets each fault selection run across every code.

// File: rtl/selftest_pkg.sv
package selftest_pkg;

   localparam int CODE_W  = 4;
   localparam int OUT_W   = 4;
   localparam int NODE_W  = 3;
   localparam int WORD_W  = OUT_W + NODE_W;

   // internal node positions inside the compared word (low bits)
   localparam int NODE_BC = 0;
   localparam int NODE_CD = 1;
   localparam int NODE_AB = 2;

   typedef logic [CODE_W-1:0] code_t;
   typedef logic [WORD_W-1:0] word_t;

   // expected compared word for an input code, taken from the specification
   function automatic word_t golden_word(input code_t c);
      logic a, b, cc, d;
      logic w, x, y, z;
      a  = c[3];
      b  = c[2];
      cc = c[1];
      d  = c[0];
      w  = (a & b) | (cc & d);
      x  = a ^ b;
      y  = ~(b | cc);
      z  = (a & ~d) | (b & cc);
      return {w, x, y, z, (a & b), (cc & d), (b & cc)};
   endfunction

endpackage

// File: rtl/stim_counter.sv
module stim_counter #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic [W-1:0] count
);

   localparam logic [W-1:0] LAST = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (step) begin
         if (count == LAST) count <= '0;
         else               count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/logic_under_test.sv
module logic_under_test
   import selftest_pkg::*;
#(
   parameter int SEL_W = 2
) (
   input  logic [CODE_W-1:0] code,
   input  logic              flip_en,
   input  logic [SEL_W-1:0]  flip_sel,
   output logic [OUT_W-1:0]  outs,
   output logic [NODE_W-1:0] nodes
);

   logic a, b, c, d;
   logic [NODE_W-1:0] raw;

   assign a = code[3];
   assign b = code[2];
   assign c = code[1];
   assign d = code[0];

   assign raw[NODE_AB] = a & b;
   assign raw[NODE_CD] = c & d;
   assign raw[NODE_BC] = b & c;

   // optional inversion of exactly one node, for fault injection
   for (genvar g = 0; g < NODE_W; g++) begin : g_node
      localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(g);
      assign nodes[g] = raw[g] ^ (flip_en && (flip_sel == MY_SEL));
   end

   assign outs[3] = nodes[NODE_AB] | nodes[NODE_CD];
   assign outs[2] = a ^ b;
   assign outs[1] = ~(b | c);
   assign outs[0] = (a & ~d) | nodes[NODE_BC];

endmodule

// File: rtl/golden_seq.sv
module golden_seq
   import selftest_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int SEQ_STYLE = 0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  step,
   output word_t expect_word
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [DEPTH-1:0][WORD_W-1:0] init_tbl;

   // reset image of the table, one computed word per code
   for (genvar g = 0; g < DEPTH; g++) begin : g_init
      localparam code_t CODE = CODE_W'(g);
      assign init_tbl[g] = golden_word(CODE);
   end

   if (SEQ_STYLE == 0) begin : g_ring
      // rotating ring: head word always at slot 0
      logic [DEPTH-1:0][WORD_W-1:0] ring;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     ring <= init_tbl;
         else if (step)  ring <= {ring[0], ring[DEPTH-1:1]};
      end
      assign expect_word = ring[0];
   end else begin : g_ptr
      // static table read through a wrapping pointer
      logic [DEPTH-1:0][WORD_W-1:0] tbl;
      logic [AW-1:0]                ptr;
      localparam logic [AW-1:0] PLAST = AW'(DEPTH - 1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tbl <= init_tbl;
            ptr <= '0;
         end else if (step) begin
            if (ptr == PLAST) ptr <= '0;
            else              ptr <= ptr + 1'b1;
         end
      end
      assign expect_word = tbl[ptr];
   end

endmodule

// File: rtl/result_cmp.sv
module result_cmp
   import selftest_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  active,
   input  word_t live_word,
   input  word_t expect_word,
   output logic  ok_q,
   output logic  warn_q
);

   logic [WORD_W-1:0] diff;
   logic              match;

   for (genvar g = 0; g < WORD_W; g++) begin : g_bit
      assign diff[g] = live_word[g] ^ expect_word[g];
   end

   assign match = ~|diff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ok_q   <= 1'b0;
         warn_q <= 1'b0;
      end else begin
         ok_q   <= active &  match;
         warn_q <= active & ~match;
      end
   end

endmodule

// File: rtl/exh_logic_selftest.sv
module exh_logic_selftest
   import selftest_pkg::*;
#(
   parameter int IN_W      = 4,
   parameter int N_NODES   = 3,
   parameter int SEQ_STYLE = 0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         test_en,
   input  logic [IN_W-1:0]              ext_in,
   input  logic                         dbg_flip_en,
   input  logic [$clog2(N_NODES)-1:0]   dbg_flip_sel,
   output logic [OUT_W-1:0]             out_wxyz,
   output logic                         ok_lamp,
   output logic                         warn_lamp
);

   localparam int SEL_W = $clog2(N_NODES);
   localparam int DEPTH = 1 << IN_W;

   if (IN_W != CODE_W) begin : g_bad_in_w
      $error("IN_W must equal the function input width");
   end
   if (N_NODES != NODE_W) begin : g_bad_nodes
      $error("N_NODES must equal the number of internal nodes");
   end
   if (SEQ_STYLE != 0 && SEQ_STYLE != 1) begin : g_bad_style
      $error("SEQ_STYLE must be 0 or 1");
   end

   logic [IN_W-1:0]   stim;
   code_t             code_mux;
   logic [NODE_W-1:0] nodes;
   word_t             live_word;
   word_t             expect_word;

   stim_counter #(.W(IN_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (test_en),
      .count (stim)
   );

   // test mode disconnects the external inputs
   assign code_mux = test_en ? stim : ext_in;

   logic_under_test #(.SEL_W(SEL_W)) u_lut (
      .code     (code_mux),
      .flip_en  (dbg_flip_en),
      .flip_sel (dbg_flip_sel),
      .outs     (out_wxyz),
      .nodes    (nodes)
   );

   assign live_word = {out_wxyz, nodes};

   golden_seq #(.DEPTH(DEPTH), .SEQ_STYLE(SEQ_STYLE)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .step        (test_en),
      .expect_word (expect_word)
   );

   result_cmp u_cmp (
      .clk         (clk),
      .rst_n       (rst_n),
      .active      (test_en),
      .live_word   (live_word),
      .expect_word (expect_word),
      .ok_q        (ok_lamp),
      .warn_q      (warn_lamp)
   );

endmodule

// File: rtl/exh_logic_selftest_chk.sv
module exh_logic_selftest_chk #(
   parameter int SEL_W   = 2,
   parameter int N_NODES = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             test_en,
   input logic             dbg_flip_en,
   input logic [SEL_W-1:0] dbg_flip_sel,
   input logic             ok_lamp,
   input logic             warn_lamp
);

   logic fault_live;
   assign fault_live = dbg_flip_en && (int'(dbg_flip_sel) < N_NODES);

   AST_LAMPS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(ok_lamp && warn_lamp));                                           // R6

   AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      !test_en |=> (!ok_lamp && !warn_lamp));                              // R7

   AST_CLEAN_OK: assert property (@(posedge clk) disable iff (!rst_n)
      (test_en && !fault_live) |=> (ok_lamp && !warn_lamp));               // R5

   AST_FAULT_WARN: assert property (@(posedge clk) disable iff (!rst_n)
      (test_en && fault_live) |=> (warn_lamp && !ok_lamp));                // R9

endmodule

bind exh_logic_selftest exh_logic_selftest_chk #(
   .SEL_W   (SEL_W),
   .N_NODES (N_NODES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .test_en      (test_en),
   .dbg_flip_en  (dbg_flip_en),
   .dbg_flip_sel (dbg_flip_sel),
   .ok_lamp      (ok_lamp),
   .warn_lamp    (warn_lamp)
);

// File: tb/exh_logic_selftest_tb.sv
`timescale 1ns/1ps
module exh_logic_selftest_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       test_en = 1'b0;
   logic [3:0] ext_in = 4'h0;
   logic       dbg_flip_en = 1'b0;
   logic [1:0] dbg_flip_sel = 2'd0;

   logic [3:0] out_a, out_b;
   logic       ok_a, ok_b, warn_a, warn_b;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   exh_logic_selftest #(.SEQ_STYLE(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .test_en(test_en), .ext_in(ext_in),
      .dbg_flip_en(dbg_flip_en), .dbg_flip_sel(dbg_flip_sel),
      .out_wxyz(out_a), .ok_lamp(ok_a), .warn_lamp(warn_a));

   exh_logic_selftest #(.SEQ_STYLE(1)) u_dut_ptr (
      .clk(clk), .rst_n(rst_n), .test_en(test_en), .ext_in(ext_in),
      .dbg_flip_en(dbg_flip_en), .dbg_flip_sel(dbg_flip_sel),
      .out_wxyz(out_b), .ok_lamp(ok_b), .warn_lamp(warn_b));

   // reference word {W,X,Y,Z,AB,CD,BC} with optional node inversion
   function automatic logic [6:0] ref_word(input logic [3:0] c, input logic fe,
                                           input logic [1:0] fs);
      logic a, b, cc, d, ab, cd, bc;
      a = c[3]; b = c[2]; cc = c[1]; d = c[0];
      ab = (a & b)  ^ (fe && fs == 2'd2);
      cd = (cc & d) ^ (fe && fs == 2'd1);
      bc = (b & cc) ^ (fe && fs == 2'd0);
      return {ab | cd, a ^ b, ~(b | cc), (a & ~d) | bc, ab, cd, bc};
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // both variants checked on every observation (R10)
   task automatic chk_out(input string req, input logic [3:0] exp);
      chk({req, " ring"}, {4'h0, out_a}, {4'h0, exp});
      chk({req, " ptr R10"}, {4'h0, out_b}, {4'h0, exp});
   endtask

   task automatic chk_lamps(input string req, input logic ok, input logic warn);
      chk({req, " ring"}, {6'h0, ok_a, warn_a}, {6'h0, ok, warn});
      chk({req, " ptr R10"}, {6'h0, ok_b, warn_b}, {6'h0, ok, warn});
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      test_en = 1'b0;
      dbg_flip_en = 1'b0;
      dbg_flip_sel = 2'd0;
      step();
      chk_lamps("R8 lamps in reset", 1'b0, 1'b0);
      rst_n = 1'b1;
      step();
   endtask

   task automatic t_idle();
      do_reset();
      for (int v = 0; v < 16; v += 5) begin
         ext_in = 4'(v);
         #1;
         chk_out("R7 R3 idle follows ext_in", ref_word(4'(v), 1'b0, 2'd0)[6:3]);
         step();
         chk_lamps("R7 idle lamps dark", 1'b0, 1'b0);
      end
   endtask

   task automatic t_sweep();
      do_reset();
      test_en = 1'b1;
      for (int i = 0; i < 34; i++) begin
         ext_in = 4'(i * 7 + 3);
         #1;
         chk_out("R1 R2 R3 counter-driven output", ref_word(4'(i % 16), 1'b0, 2'd0)[6:3]);
         step();
         chk_lamps("R5 clean ok", 1'b1, 1'b0);
      end
   endtask

   task automatic t_hold();
      do_reset();
      test_en = 1'b1;
      repeat (5) step();
      test_en = 1'b0;
      for (int k = 0; k < 3; k++) begin
         ext_in = 4'(k + 9);
         #1;
         chk_out("R7 paused output follows ext_in", ref_word(4'(k + 9), 1'b0, 2'd0)[6:3]);
         step();
         chk_lamps("R7 paused lamps dark", 1'b0, 1'b0);
      end
      test_en = 1'b1;
      #1;
      chk_out("R7 R2 resumes at code 5", ref_word(4'd5, 1'b0, 2'd0)[6:3]);
      step();
      chk_lamps("R7 R5 table still aligned", 1'b1, 1'b0);
   endtask

   task automatic t_fault(input logic [1:0] sel);
      do_reset();
      test_en = 1'b1;
      dbg_flip_en = 1'b1;
      dbg_flip_sel = sel;
      for (int i = 0; i < 16; i++) begin
         #1;
         chk_out("R9 faulted output", ref_word(4'(i), 1'b1, sel)[6:3]);
         step();
         if (sel == 2'd3)
            chk_lamps("R9 sel 3 no effect", 1'b1, 1'b0);
         else if (ref_word(4'(i), 1'b1, sel)[6:3] == ref_word(4'(i), 1'b0, 2'd0)[6:3])
            chk_lamps("R4 R6 node-only fault warns", 1'b0, 1'b1);
         else
            chk_lamps("R6 R9 fault warns", 1'b0, 1'b1);
      end
      dbg_flip_en = 1'b0;
   endtask

   task automatic t_midreset();
      do_reset();
      test_en = 1'b1;
      repeat (7) step();
      rst_n = 1'b0;
      #1;
      chk_lamps("R8 async clear of lamps", 1'b0, 1'b0);
      chk_out("R8 counter back to code 0", ref_word(4'd0, 1'b0, 2'd0)[6:3]);
      step();
      rst_n = 1'b1;
      step();
      chk_lamps("R8 R5 realigned after reset", 1'b1, 1'b0);
      #1;
      chk_out("R8 R2 next code after reset", ref_word(4'd1, 1'b0, 2'd0)[6:3]);
      test_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_idle();
      t_sweep();
      t_hold();
      for (int s = 0; s < 4; s++) t_fault(2'(s));
      t_midreset();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule